// File: doc/BRIEF.md
# JTAG-Loaded At-Speed Memory Pattern Player

This block is a test engine that sits behind a user-defined JTAG data register inside an FPGA. The host reaches it through the FPGA's USER1 instruction. It does not use the boundary-scan register. Over that slow serial path the host loads a batch of memory-bus vectors into an internal buffer. Each vector is a write or a read, and each carries an address and a data byte; for a read, the data byte is the value the host expects back. Every vector stays in the buffer until a run begins.

On a start command, the block crosses into the system clock domain through a request/acknowledge handshake. It then plays the selected number of vectors against the target bus with one access per system clock and no pauses. This keeps the gap between accesses far below any refresh limit of the target. Each read response is compared with its expected byte. Every mismatch stores the vector index and the observed byte in a result queue, and it also increments a saturating error counter. When the run is over, the host shifts out the status and pops the stored results one at a time.

Top module: `atspeed_player`

## Requirements
- R1: A data-register frame is DRW bits long and is shifted in least significant bit first. Bit 25 is pop, bits 24:23 are the op (0 none, 1 load, 2 depth, 3 start), bits 22:17 are the entry index and bits 16:0 are the vector. In the vector, bit 16 is set for a read, bits 15:8 are the address and bits 7:0 are the data. A load op on update stores the vector into the buffer entry given by the index.
- R2: The depth op sets the run length from vector bits 6:0, clamped to 64. A run applies entries 0 to depth-1 in index order.
- R3: During a run the block makes exactly one access per system clock cycle with no idle cycle between the first and the last access. A write drives mem_we, mem_addr and mem_wdata. A read drives mem_re and mem_addr. The two strobes are never both high.
- R4: Read data is sampled one cycle after mem_re. On a mismatch, the vector index and the observed byte are appended to a result queue of 64 entries. The queue is kept in order, and mismatches beyond 64 are dropped.
- R5: The error counter counts mismatches in the current run and holds at 2^ERRW-1.
- R6: After an accepted start, busy reads 1 until the run has completed and been acknowledged back into the TCK domain. At that point busy reads 0 and done reads 1.
- R7: While busy is set, a load, depth or start op changes nothing, and it sets the reject flag. The reject flag stays set until the next accepted start clears it.
- R8: On capture, the register loads a status word at its LSB end. From the most significant bit down, the word holds busy, done, reject, has-result, the error count (ERRW bits), the head result index (6 bits) and the head result data (8 bits). The error count and head fields read 0 unless done is set. A frame with pop set, sent while done and a result is present, advances the head.
- R9: After reset the status word is all zero and neither strobe is asserted.
- R10: A run with depth 0 completes with done set, no access and zero errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | TCK-domain reset, active low |
| dr_sel | input | 1 | USER1 data register selected |
| dr_capture | input | 1 | Capture-DR state strobe |
| dr_shift | input | 1 | Shift-DR state strobe |
| dr_update | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| clk | input | 1 | System clock |
| rst_n | input | 1 | System-domain reset, active low |
| mem_we | output | 1 | Target write strobe |
| mem_re | output | 1 | Target read strobe |
| mem_addr | output | AW | Target address |
| mem_wdata | output | DW | Target write data |
| mem_rdata | input | DW | Target read data, valid the cycle after mem_re |

## Verification
Some behaviours are checked by assertions on every clock edge. These are: only one strobe high at a time; no strobe re-appearing once accesses have stopped within a run; the error counter stepping by at most one and holding once saturated; the result pointer never passing the queue depth; the acknowledge never being high while a run is active; and the depth register holding while busy. Other behaviours can only be shown by the bench scenarios. These are the full mismatch list with its indices and observed bytes, queue order under popping, saturation at 64 failing reads, depth clamping, rejection of commands during a run whose system clock is held, and the empty run.

// File: rtl/atspeed_player.sv
`timescale 1ns/1ps
module atspeed_player #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int DEPTH = 64,
  parameter int ERRW = 8
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          dr_sel,
  input  logic          dr_capture,
  input  logic          dr_shift,
  input  logic          dr_update,
  input  logic          tdi,
  output logic          tdo,
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IW  = $clog2(DEPTH);
  localparam int CW  = IW + 1;
  localparam int VW  = 1 + AW + DW;
  localparam int FW  = 3 + IW + VW;
  localparam int SW  = 4 + ERRW + IW + DW;
  localparam int DRW = (FW > SW) ? FW : SW;

  localparam logic [1:0] OP_NOP = 2'd0, OP_LOAD = 2'd1, OP_DEPTH = 2'd2, OP_START = 2'd3;

  logic [DRW-1:0] sr;
  logic [VW-1:0]  vbuf [DEPTH];
  logic [CW-1:0]  depth_t, rp_t;
  logic           req_t, done_t, rej_t;
  logic [1:0]     ack_sync;

  logic [1:0]     req_sync;
  logic           ack_s, run_s, pend_s;
  logic [CW-1:0]  ix_s, wp_s;
  logic [IW-1:0]  pix_s;
  logic [DW-1:0]  pexp_s;
  logic [ERRW-1:0] err_s;
  logic [IW-1:0]  res_idx [DEPTH];
  logic [DW-1:0]  res_dat [DEPTH];

  wire          busy_t = req_t | ack_sync[1];
  wire          f_pop  = sr[FW-1];
  wire [1:0]    f_op   = sr[FW-2 -: 2];
  wire [IW-1:0] f_idx  = sr[VW +: IW];
  wire [VW-1:0] f_vec  = sr[VW-1:0];
  wire          upd    = dr_sel & dr_update;
  wire          has_res = done_t && (rp_t < wp_s);
  wire [CW-1:0] new_depth = (f_vec[CW-1:0] > CW'(DEPTH)) ? CW'(DEPTH) : f_vec[CW-1:0];

  wire [SW-1:0] status = {busy_t, done_t, rej_t, has_res,
                          done_t ? err_s : '0,
                          has_res ? res_idx[rp_t[IW-1:0]] : '0,
                          has_res ? res_dat[rp_t[IW-1:0]] : '0};

  assign tdo = sr[0];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= '0; depth_t <= '0; rp_t <= '0;
      req_t <= 1'b0; done_t <= 1'b0; rej_t <= 1'b0; ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[0], ack_s};
      if (req_t && ack_sync[1]) begin
        req_t  <= 1'b0;
        done_t <= 1'b1;
      end
      if (dr_sel && dr_capture)    sr <= DRW'(status);
      else if (dr_sel && dr_shift) sr <= {tdi, sr[DRW-1:1]};
      if (upd) begin
        if (f_pop && has_res && !busy_t) rp_t <= rp_t + CW'(1);
        if (f_op != OP_NOP && busy_t) rej_t <= 1'b1;
        else if (f_op == OP_DEPTH) depth_t <= new_depth;
        else if (f_op == OP_START) begin
          req_t <= 1'b1; done_t <= 1'b0; rej_t <= 1'b0; rp_t <= '0;
        end
      end
    end
  end

  always_ff @(posedge tck)
    if (upd && f_op == OP_LOAD && !busy_t && ({1'b0, f_idx} < CW'(DEPTH)))
      vbuf[f_idx] <= f_vec;

  wire [VW-1:0] cur   = vbuf[ix_s[IW-1:0]];
  wire          issue = run_s && (ix_s < depth_t);
  wire          miss  = pend_s && (mem_rdata != pexp_s);

  assign mem_we    = issue & ~cur[VW-1];
  assign mem_re    = issue &  cur[VW-1];
  assign mem_addr  = issue ? cur[DW +: AW] : '0;
  assign mem_wdata = mem_we ? cur[DW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0; ack_s <= 1'b0; run_s <= 1'b0; pend_s <= 1'b0;
      ix_s <= '0; wp_s <= '0; pix_s <= '0; pexp_s <= '0; err_s <= '0;
    end else begin
      req_sync <= {req_sync[0], req_t};
      if (!run_s && !ack_s && req_sync[1]) begin
        run_s <= 1'b1; ix_s <= '0; err_s <= '0; wp_s <= '0; pend_s <= 1'b0;
      end else if (run_s) begin
        pend_s <= mem_re;
        pix_s  <= ix_s[IW-1:0];
        pexp_s <= cur[DW-1:0];
        if (issue) ix_s <= ix_s + CW'(1);
        if (miss) begin
          if (err_s != '1) err_s <= err_s + ERRW'(1);
          if (wp_s < CW'(DEPTH)) wp_s <= wp_s + CW'(1);
        end
        if (!issue && !pend_s) begin
          run_s <= 1'b0;
          ack_s <= 1'b1;
        end
      end
      if (ack_s && !req_sync[1]) ack_s <= 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (run_s && miss && wp_s < CW'(DEPTH)) begin
      res_idx[wp_s[IW-1:0]] <= pix_s;
      res_dat[wp_s[IW-1:0]] <= mem_rdata;
    end
endmodule

// File: rtl/atspeed_player_checks.sv
`timescale 1ns/1ps
module atspeed_player_checks #(
  parameter int ERRW = 8,
  parameter int CW = 7,
  parameter int DEPTH = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tck,
  input logic            trst_n,
  input logic            mem_we,
  input logic            mem_re,
  input logic            run_s,
  input logic            ack_s,
  input logic [ERRW-1:0] err_s,
  input logic [CW-1:0]   wp_s,
  input logic            busy_t,
  input logic [CW-1:0]   depth_t
);
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_s && !(mem_we || mem_re) |=> !(mem_we || mem_re));

  assert_err_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_s && err_s == '1 |=> err_s == '1);

  assert_err_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_s |=> (err_s == $past(err_s) || err_s == $past(err_s) + ERRW'(1)));

  assert_queue_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wp_s <= CW'(DEPTH));

  assert_ack_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_s |-> !run_s);

  assert_depth_frozen_R7: assert property (@(posedge tck) disable iff (!trst_n)
    busy_t |=> $stable(depth_t));
endmodule

bind atspeed_player atspeed_player_checks #(.ERRW(ERRW), .CW(CW), .DEPTH(DEPTH)) u_checks (
  .clk(clk), .rst_n(rst_n), .tck(tck), .trst_n(trst_n),
  .mem_we(mem_we), .mem_re(mem_re), .run_s(run_s), .ack_s(ack_s),
  .err_s(err_s), .wp_s(wp_s), .busy_t(busy_t), .depth_t(depth_t));

// File: tb/sim_atspeed_player.sv
`timescale 1ns/1ps
module sim_atspeed_player;
  localparam int DRW = 26;
  localparam int NT = 12;
  localparam logic [16:0] TBL [NT] = '{
    {1'b0, 8'h10, 8'h5A}, {1'b0, 8'h33, 8'hA5}, {1'b0, 8'h20, 8'hC3},
    {1'b1, 8'h10, 8'h5A}, {1'b1, 8'h33, 8'hA5}, {1'b1, 8'h20, 8'h3C},
    {1'b0, 8'h21, 8'h0F}, {1'b1, 8'h21, 8'h0F}, {1'b1, 8'h40, 8'h00},
    {1'b0, 8'h10, 8'h77}, {1'b1, 8'h10, 8'h77}, {1'b1, 8'h33, 8'hA5}};

  logic clk = 0, clk_en = 1, rst_n = 0, tck = 0, trst_n = 0;
  logic sel = 0, cap = 0, shf = 0, upd = 0, tdi = 0;
  logic [7:0] rdata = 0;
  wire tdo, we, re;
  wire [7:0] addr, wdata;

  int ntest = 0, nfail = 0;
  int cyc = 0, nacc = 0, first_c = 0, last_c = 0;
  logic [16:0] log_v [64];
  logic [7:0] mem [256];
  logic [DRW-1:0] st;

  atspeed_player #(.ERRW(4)) u0 (
    .tck(tck), .trst_n(trst_n), .dr_sel(sel), .dr_capture(cap), .dr_shift(shf),
    .dr_update(upd), .tdi(tdi), .tdo(tdo), .clk(clk), .rst_n(rst_n),
    .mem_we(we), .mem_re(re), .mem_addr(addr), .mem_wdata(wdata), .mem_rdata(rdata));

  always #2.5 if (clk_en) clk = ~clk;
  always #10 tck = ~tck;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr] ^ ((addr == 8'h33) ? 8'h04 : 8'h00);
  end

  always @(negedge clk) begin
    cyc++;
    if (we || re) begin
      if (nacc < 64) log_v[nacc] = {re, addr, re ? 8'h00 : wdata};
      if (nacc == 0) first_c = cyc;
      last_c = cyc;
      nacc++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    ntest++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DRW-1:0] frame(input bit pop, input logic [1:0] op,
                                           input logic [5:0] idx, input logic [16:0] vec);
    return {pop, op, idx, vec};
  endfunction

  task automatic scan(input logic [DRW-1:0] din);
    @(negedge tck) begin sel = 1; cap = 1; end
    @(negedge tck) begin cap = 0; shf = 1; end
    for (int i = 0; i < DRW; i++) begin
      st[i] = tdo;
      tdi = din[i];
      @(negedge tck);
    end
    shf = 0; upd = 1;
    @(negedge tck) begin upd = 0; sel = 0; end
  endtask

  task automatic wait_done();
    for (int k = 0; k < 100; k++) begin
      scan(frame(0, 2'd0, 6'd0, 17'd0));
      if (st[20] && !st[21]) break;
    end
  endtask

  task automatic start_run();
    nacc = 0;
    scan(frame(0, 2'd3, 6'd0, 17'd0));
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    logic [7:0] ref_m [256];
    int exp_idx [NT];
    logic [7:0] exp_dat [NT];
    int nexp = 0;
    logic [7:0] obs;

    repeat (3) @(negedge tck);
    trst_n = 1; rst_n = 1;
    repeat (2) @(negedge tck);

    // R9: reset state
    scan(frame(0, 2'd0, 6'd0, 17'd0));
    chk("R9 status", int'(st), 0);
    chk("R9 strobes", {30'd0, we, re}, 0);

    // R1: load table through one loop
    for (int i = 0; i < NT; i++) scan(frame(0, 2'd1, 6'(i), TBL[i]));
    scan(frame(0, 2'd2, 6'd0, 17'(NT)));
    for (int i = 0; i < 256; i++) ref_m[i] = 8'h00;
    for (int i = 0; i < NT; i++) begin
      if (!TBL[i][16]) ref_m[TBL[i][15:8]] = TBL[i][7:0];
      else begin
        obs = ref_m[TBL[i][15:8]] ^ ((TBL[i][15:8] == 8'h33) ? 8'h04 : 8'h00);
        if (obs != TBL[i][7:0]) begin exp_idx[nexp] = i; exp_dat[nexp] = obs; nexp++; end
      end
    end

    start_run();
    scan(frame(0, 2'd0, 6'd0, 17'd0));
    chk("R6 busy after start", int'(st[21]), 1);
    wait_done();
    chk("R6 done", int'(st[20]), 1);
    chk("R2 access count", nacc, NT);
    chk("R3 contiguous", last_c - first_c + 1, NT);
    for (int i = 0; i < NT; i++)
      chk("R1 R2 trace order", int'(log_v[i]), int'({TBL[i][16:8], TBL[i][16] ? 8'h00 : TBL[i][7:0]}));
    chk("R5 error count", int'(st[17:14]), nexp);
    for (int k = 0; k < nexp; k++) begin
      scan(frame(1, 2'd0, 6'd0, 17'd0));
      chk("R8 has result", int'(st[18]), 1);
      chk("R4 head index", int'(st[13:8]), exp_idx[k]);
      chk("R4 head data", int'(st[7:0]), int'(exp_dat[k]));
    end
    scan(frame(0, 2'd0, 6'd0, 17'd0));
    chk("R8 queue drained", int'(st[18]), 0);

    // R7: commands during a run whose system clock is held
    @(negedge clk) clk_en = 0;
    start_run();
    scan(frame(0, 2'd1, 6'd0, {1'b0, 8'h10, 8'h99}));
    scan(frame(0, 2'd2, 6'd0, 17'd3));
    scan(frame(0, 2'd0, 6'd0, 17'd0));
    chk("R6 busy held", int'(st[21]), 1);
    chk("R7 reject flag", int'(st[19]), 1);
    clk_en = 1;
    wait_done();
    chk("R7 depth kept", nacc, NT);
    chk("R7 entry kept", int'(log_v[0]), int'(TBL[0]));
    chk("R7 errors unchanged", int'(st[17:14]), nexp);
    chk("R7 reject sticky", int'(st[19]), 1);

    // R10: empty run
    scan(frame(0, 2'd2, 6'd0, 17'd0));
    start_run();
    wait_done();
    chk("R10 done", int'(st[20]), 1);
    chk("R10 no access", nacc, 0);
    chk("R10 no errors", int'(st[17:14]), 0);
    chk("R7 reject cleared", int'(st[19]), 0);

    // R2 clamp, R4 full queue, R5 saturation
    for (int i = 0; i < 64; i++) scan(frame(0, 2'd1, 6'(i), {1'b1, 8'h77, 8'hFF}));
    scan(frame(0, 2'd2, 6'd0, 17'd100));
    start_run();
    wait_done();
    chk("R2 clamped length", nacc, 64);
    chk("R3 contiguous full", last_c - first_c + 1, 64);
    chk("R5 saturated", int'(st[17:14]), 15);
    for (int k = 0; k < 64; k++) begin
      scan(frame(1, 2'd0, 6'd0, 17'd0));
      chk("R4 full index", int'(st[13:8]), k);
      chk("R4 full data", int'(st[7:0]), 0);
    end
    scan(frame(0, 2'd0, 6'd0, 17'd0));
    chk("R4 queue empty", int'(st[18]), 0);

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule